// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two 8-bit buses, called A and B, and keeps one storage register for each bus. Each bus appears as three separate signals: an input, an output and an output enable. There are no tri-state pins. An active-low enable and a direction input decide which bus, if either, the block drives. For each direction a source select picks what goes onto the driven bus: the live value of the opposite bus, or the value held in that bus's register.

Each register has its own capture clock and loads its own bus on every rising edge of that clock. Capture does not depend on the enable, the direction or the selects, so data can be stored while the block is isolated. The output enables and output values are combinational functions of the inputs and the register contents. A synchronous active-high reset clears each register on that register's own clock. The reset exists so that simulation starts from a known state.

Top module: `xcvr_bus_bridge`

## Requirements
- R1: When `en_n` is 1, both `a_oe` and `b_oe` are 0, whatever `dir`, `sel_ab` and `sel_ba` are.
- R2: On each rising edge of `clk_ab` with `rst` at 0, the A register loads `a_in`. This happens whatever `en_n`, `dir` and the selects are.
- R3: On each rising edge of `clk_ba` with `rst` at 0, the B register loads `b_in`. This happens whatever `en_n`, `dir` and the selects are.
- R4: With `en_n`=0 and `dir`=0: `a_oe`=1 and `b_oe`=0. If `sel_ba`=0, `a_out` equals the live `b_in`.
- R5: With `en_n`=0, `dir`=0 and `sel_ba`=1, `a_out` equals the B register.
- R6: With `en_n`=0 and `dir`=1: `b_oe`=1 and `a_oe`=0. If `sel_ab`=0, `b_out` equals the live `a_in`.
- R7: With `en_n`=0, `dir`=1 and `sel_ab`=1, `b_out` equals the A register.
- R8: `a_oe` and `b_oe` are never 1 at the same time.
- R9: A capture on either clock while `en_n`=1 stores the bus value. That value then appears when the stored source is selected.
- R10: A rising edge of a capture clock with `rst`=1 clears that register to zero.
- R11: Without a capture clock edge, the register contents do not change when the controls or the bus inputs change.
- R12: Outputs follow changes of the inputs with no clock edge in between. There is no pipeline stage.
- R13: An output whose enable is 0 reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Capture clock for the A register |
| clk_ba | input | 1 | Capture clock for the B register |
| rst | input | 1 | Synchronous active-high reset, sampled on each capture clock |
| en_n | input | 1 | Active-low enable for both outputs |
| dir | input | 1 | 0 drives bus A, 1 drives bus B |
| sel_ab | input | 1 | Source for bus B: 0 live A, 1 stored A |
| sel_ba | input | 1 | Source for bus A: 0 live B, 1 stored B |
| a_in | input | 8 | Value present on bus A |
| b_in | input | 8 | Value present on bus B |
| a_out | output | 8 | Value to drive onto bus A |
| a_oe | output | 1 | Bus A drive enable |
| b_out | output | 8 | Value to drive onto bus B |
| b_oe | output | 1 | Bus B drive enable |

## Verification
The bench walks all sixteen settings of enable, direction and the two selects. It does this under several pairs of bus values and register contents, including all-zeros, all-ones and the complementary patterns 0xA5 and 0x5A. Live and stored values always differ, so any swap of source, direction or enable shows up as a wrong value. A separate scenario loads the registers, then changes the controls and bus inputs with no clock edge, and reads the stored values back. This separates holding from re-capture. Captures taken while isolated, and reset on each clock, are checked through the stored-source outputs.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int XCVR_WIDTH = 8;

    typedef enum logic [1:0] {
        DRV_NONE = 2'd0,
        DRV_TO_A = 2'd1,
        DRV_TO_B = 2'd2
    } drive_e;

    typedef struct packed {
        logic en_n;
        logic dir;
        logic sel_ab;
        logic sel_ba;
    } ctrl_t;

    function automatic drive_e decode_drive(input logic en_n, input logic dir);
        if (en_n)
            return DRV_NONE;
        else if (dir)
            return DRV_TO_B;
        else
            return DRV_TO_A;
    endfunction

endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= d;
    end

    // R2 R3
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (q == $past(d)));

endmodule

// File: rtl/xcvr_drive_decode.sv
module xcvr_drive_decode
    import xcvr_pkg::*;
(
    input  logic   en_n,
    input  logic   dir,
    output drive_e drv,
    output logic   a_oe,
    output logic   b_oe
);

    always_comb begin
        drv  = decode_drive(en_n, dir);
        a_oe = (drv == DRV_TO_A);
        b_oe = (drv == DRV_TO_B);
    end

endmodule

// File: rtl/xcvr_src_mux.sv
module xcvr_src_mux #(
    parameter int W = 8
) (
    input  logic         oe,
    input  logic         use_stored,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] y
);

    for (genvar i = 0; i < W; i++) begin : g_chan
        assign y[i] = oe & (use_stored ? stored[i] : live[i]);
    end

endmodule

// File: rtl/xcvr_bus_bridge.sv
module xcvr_bus_bridge
    import xcvr_pkg::*;
#(
    parameter int W = XCVR_WIDTH
) (
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  logic         rst,
    input  logic         en_n,
    input  logic         dir,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe
);

    ctrl_t        ctrl;
    drive_e       drv;
    logic [W-1:0] reg_a;
    logic [W-1:0] reg_b;

    assign ctrl = '{en_n: en_n, dir: dir, sel_ab: sel_ab, sel_ba: sel_ba};

    xcvr_store_reg #(.W(W)) u_reg_a (
        .clk (clk_ab),
        .rst (rst),
        .d   (a_in),
        .q   (reg_a)
    );

    xcvr_store_reg #(.W(W)) u_reg_b (
        .clk (clk_ba),
        .rst (rst),
        .d   (b_in),
        .q   (reg_b)
    );

    xcvr_drive_decode u_dec (
        .en_n (ctrl.en_n),
        .dir  (ctrl.dir),
        .drv  (drv),
        .a_oe (a_oe),
        .b_oe (b_oe)
    );

    xcvr_src_mux #(.W(W)) u_mux_to_b (
        .oe         (b_oe),
        .use_stored (ctrl.sel_ab),
        .live       (a_in),
        .stored     (reg_a),
        .y          (b_out)
    );

    xcvr_src_mux #(.W(W)) u_mux_to_a (
        .oe         (a_oe),
        .use_stored (ctrl.sel_ba),
        .live       (b_in),
        .stored     (reg_b),
        .y          (a_out)
    );

    always_comb begin
        // R8
        oe_excl_chk: assert (!(a_oe && b_oe));
        // R1
        iso_chk: assert (!en_n || (!a_oe && !b_oe));
        // R4
        live_ba_chk: assert (!(a_oe && !sel_ba) || (a_out == b_in));
        // R6
        live_ab_chk: assert (!(b_oe && !sel_ab) || (b_out == a_in));
        // R13
        idle_zero_chk: assert ((a_oe || a_out == '0) && (b_oe || b_out == '0));
    end

endmodule

// File: tb/xcvr_bus_bridge_test.sv
module xcvr_bus_bridge_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         clk_ab = 1'b0;
    logic         clk_ba = 1'b0;
    logic         rst = 1'b1;
    logic         en_n = 1'b1;
    logic         dir = 1'b0;
    logic         sel_ab = 1'b0;
    logic         sel_ba = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] a_out;
    logic         a_oe;
    logic [W-1:0] b_out;
    logic         b_oe;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic [W-1:0] mdl_a = '0;
    logic [W-1:0] mdl_b = '0;

    xcvr_bus_bridge #(.W(W)) uut (
        .clk_ab (clk_ab), .clk_ba (clk_ba), .rst (rst),
        .en_n (en_n), .dir (dir), .sel_ab (sel_ab), .sel_ba (sel_ba),
        .a_in (a_in), .b_in (b_in),
        .a_out (a_out), .a_oe (a_oe), .b_out (b_out), .b_oe (b_oe)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 100000) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic do_a, input logic do_b);
        #1;
        clk_ab = do_a;
        clk_ba = do_b;
        if (do_a) mdl_a = rst ? '0 : a_in;
        if (do_b) mdl_b = rst ? '0 : b_in;
        #2;
        clk_ab = 1'b0;
        clk_ba = 1'b0;
        #1;
    endtask

    task automatic set_ctrl(input logic [3:0] c);
        {en_n, dir, sel_ab, sel_ba} = c;
    endtask

    // full check of all outputs against the model
    task automatic check_all(input string tag);
        logic         ea, eb;
        logic [W-1:0] va, vb;
        #1;
        ea = !en_n && !dir;
        eb = !en_n && dir;
        va = ea ? (sel_ba ? mdl_b : b_in) : '0;
        vb = eb ? (sel_ab ? mdl_a : a_in) : '0;
        chk({tag, " a_oe"}, {{W{1'b0}}, a_oe}, {{W{1'b0}}, ea});
        chk({tag, " b_oe"}, {{W{1'b0}}, b_oe}, {{W{1'b0}}, eb});
        chk({tag, " a_out"}, {1'b0, a_out}, {1'b0, va});
        chk({tag, " b_out"}, {1'b0, b_out}, {1'b0, vb});
        chk({tag, " R8 excl"}, {{W{1'b0}}, a_oe & b_oe}, '0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        a_in = 8'hFF; b_in = 8'hFF;
        pulse(1'b1, 1'b1);
        rst = 1'b0;
        set_ctrl(4'b0110); // drive B from stored A
        #1; chk("R10 reg A cleared", {1'b0, b_out}, {1'b0, 8'h00});
        set_ctrl(4'b0001); // drive A from stored B
        #1; chk("R10 reg B cleared", {1'b0, a_out}, {1'b0, 8'h00});
        check_all("R10 reset state");
    endtask

    task automatic t_combos;
        logic [W-1:0] pats [4] = '{8'h00, 8'hFF, 8'hA5, 8'h5A};
        for (int p = 0; p < 4; p++) begin
            a_in = pats[p]; b_in = ~pats[p];
            pulse(1'b1, 1'b1);
            a_in = ~pats[p]; b_in = pats[p];
            for (int c = 0; c < 16; c++) begin
                set_ctrl(c[3:0]);
                check_all("R1 R4 R5 R6 R7 R13 combo");
            end
        end
    endtask

    task automatic t_capture_isolated;
        set_ctrl(4'b1011);
        a_in = 8'h3C; b_in = 8'hC3;
        pulse(1'b1, 1'b0);
        check_all("R1 isolated");
        pulse(1'b0, 1'b1);
        a_in = 8'h00; b_in = 8'h00;
        set_ctrl(4'b0110);
        #1; chk("R9 R2 stored A while isolated", {1'b0, b_out}, {1'b0, 8'h3C});
        set_ctrl(4'b0001);
        #1; chk("R9 R3 stored B while isolated", {1'b0, a_out}, {1'b0, 8'hC3});
    endtask

    task automatic t_independent_clocks;
        a_in = 8'h11; b_in = 8'h22;
        pulse(1'b1, 1'b1);
        a_in = 8'h99; b_in = 8'h77;
        pulse(1'b1, 1'b0); // only A captures
        set_ctrl(4'b0001);
        #1; chk("R3 B untouched by A clock", {1'b0, a_out}, {1'b0, 8'h22});
        set_ctrl(4'b0110);
        #1; chk("R2 A captured", {1'b0, b_out}, {1'b0, 8'h99});
        pulse(1'b0, 1'b1);
        set_ctrl(4'b0001);
        #1; chk("R3 B captured", {1'b0, a_out}, {1'b0, 8'h77});
    endtask

    task automatic t_hold;
        a_in = 8'h5A; b_in = 8'hC3;
        pulse(1'b1, 1'b1);
        for (int k = 0; k < 16; k++) begin
            set_ctrl(k[3:0]);
            a_in = 8'(k * 17); b_in = 8'(~(k * 29));
            #1;
        end
        a_in = 8'h00; b_in = 8'hFF;
        set_ctrl(4'b0110);
        #1; chk("R11 reg A held", {1'b0, b_out}, {1'b0, 8'h5A});
        set_ctrl(4'b0001);
        #1; chk("R11 reg B held", {1'b0, a_out}, {1'b0, 8'hC3});
    endtask

    task automatic t_live_follow;
        set_ctrl(4'b0100);
        a_in = 8'h81;
        #1; chk("R12 R6 live A follows", {1'b0, b_out}, {1'b0, 8'h81});
        a_in = 8'h18;
        #1; chk("R12 R6 live A follows again", {1'b0, b_out}, {1'b0, 8'h18});
        set_ctrl(4'b0000);
        b_in = 8'h42;
        #1; chk("R12 R4 live B follows", {1'b0, a_out}, {1'b0, 8'h42});
        b_in = 8'h24;
        #1; chk("R12 R4 live B follows again", {1'b0, a_out}, {1'b0, 8'h24});
    endtask

    task automatic t_reset_one_clock;
        a_in = 8'hEE; b_in = 8'hDD;
        pulse(1'b1, 1'b1);
        rst = 1'b1;
        pulse(1'b1, 1'b0);
        rst = 1'b0;
        set_ctrl(4'b0110);
        #1; chk("R10 A cleared by its clock", {1'b0, b_out}, {1'b0, 8'h00});
        set_ctrl(4'b0001);
        #1; chk("R10 B kept without its clock", {1'b0, a_out}, {1'b0, 8'hDD});
    endtask

    initial begin
        #1;
        t_reset;
        t_combos;
        t_capture_isolated;
        t_independent_clocks;
        t_hold;
        t_live_follow;
        t_reset_one_clock;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule